// File: doc/BRIEF.md
# Palette Lookup with Colour Cycling

This block turns a stream of 8-bit colour indices into 12-bit RGB pixels for a VGA-style display path. It keeps a 256-entry colour table that a host can rewrite at any moment, including while a frame is being scanned out. The new value shows up on the very next pixel that looks that entry up.

A host-programmed window of consecutive indices can be set to rotate by itself, so colour cycling runs with no CPU involvement. The rotation is done by remapping indices as they arrive, not by moving table data. A frame-rate divider decides how often the rotation steps. Pixels whose index lies outside the window are looked up unchanged.

Top module: `palette_cycler`

## Requirements
- R1: After reset, `rgb_valid` and `rgb_out` are 0, and the window start, window end, speed, rotation offset and frame count are all 0, so every index looks itself up. Table contents after reset are undefined.
- R2: A valid pixel with index i produces the 12-bit entry at the looked-up address, unchanged: red in bits 11:8, green in bits 7:4, blue in bits 3:0.
- R3: `rgb_valid` equals `pix_valid` delayed by exactly two clock cycles, and `rgb_out` carries the colour of that same pixel.
- R4: A host write is taken when `host_we` is 1. `host_sel` picks the target: 0 writes entry `host_addr` with `host_data`; 1 sets the window start; 2 sets the window end; 3 sets the speed. The three registers take `host_data[7:0]`, and the upper bits are ignored.
- R5: A table write presented in the same cycle as a pixel that reads the same entry gives that pixel the old colour. A pixel presented in any later cycle gets the new colour.
- R6: When start ≤ end, an index i with start ≤ i ≤ end is looked up at start + ((i − start + offset) mod (end − start + 1)). The offset always stays below end − start + 1.
- R7: Indices outside the window pass through unchanged. A window with start > end is disabled: every index passes through and the offset never steps.
- R8: With speed N ≠ 0 and the window enabled, the offset steps by one (wrapping to 0 after end − start) on every N-th `frame_start` pulse. With N = 0, the offset holds.
- R9: Any write to the start, end or speed register clears the offset and the frame count in that cycle. This write wins over a `frame_start` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel index valid |
| pix_index | input | 8 | Colour index of the pixel |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 entry, 1 start, 2 end, 3 speed |
| host_addr | input | 8 | Table entry address for entry writes |
| host_data | input | 12 | Entry colour, or register value in bits 7:0 |
| rgb_valid | output | 1 | Output pixel valid |
| rgb_out | output | 12 | Output colour, R[11:8] G[7:4] B[3:0] |

## Verification
The bench builds the block with its default parameters: an 8-bit index (256 entries), 4 bits per channel, an 8-bit speed register and cycling enabled. With these values a window covering the whole table can be set. Its length of 256 needs the extra length bit, and stepping the offset through all 256 positions checks the wrap at that full length. The 8-bit speed lets the bench try both a divider of one and a divider of three, which tests the step-on-every-N-th-frame counting.

// File: rtl/pcyc_pkg.sv
package pcyc_pkg;

   typedef enum logic [1:0] {
      SEL_ENTRY = 2'd0,
      SEL_START = 2'd1,
      SEL_END   = 2'd2,
      SEL_SPEED = 2'd3
   } host_sel_e;

endpackage

// File: rtl/pcyc_ctrl.sv
module pcyc_ctrl
   import pcyc_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int SPEED_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               host_we,
   input  logic [1:0]         host_sel,
   input  logic [IDX_W-1:0]   host_idx_val,
   input  logic [SPEED_W-1:0] host_spd_val,
   output logic [IDX_W-1:0]   win_start,
   output logic [IDX_W-1:0]   win_end,
   output logic [SPEED_W-1:0] speed,
   output logic [IDX_W-1:0]   offset,
   output logic               win_on
);
   localparam int LEN_W = IDX_W + 1;

   logic [SPEED_W-1:0] fcnt_q;
   logic [LEN_W-1:0]   win_len;
   logic [LEN_W-1:0]   off_inc;
   logic               cfg_wr;
   logic               count_en;

   assign win_on   = (win_start <= win_end);
   assign win_len  = {1'b0, win_end} - {1'b0, win_start} + LEN_W'(1);
   assign off_inc  = {1'b0, offset} + LEN_W'(1);
   assign cfg_wr   = host_we && (host_sel != SEL_ENTRY);
   assign count_en = frame_start && win_on && (speed != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_start <= '0;
         win_end   <= '0;
         speed     <= '0;
         offset    <= '0;
         fcnt_q    <= '0;
      end else if (cfg_wr) begin
         case (host_sel)
            SEL_START: win_start <= host_idx_val;
            SEL_END:   win_end   <= host_idx_val;
            default:   speed     <= host_spd_val;
         endcase
         offset <= '0;
         fcnt_q <= '0;
      end else if (count_en) begin
         if (fcnt_q == speed - SPEED_W'(1)) begin
            fcnt_q <= '0;
            offset <= (off_inc == win_len) ? '0 : IDX_W'(off_inc);
         end else begin
            fcnt_q <= fcnt_q + SPEED_W'(1);
         end
      end
   end

endmodule

// File: rtl/pcyc_remap.sv
module pcyc_remap #(
   parameter int IDX_W    = 8,
   parameter bit CYCLE_EN = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [IDX_W-1:0] win_start,
   input  logic [IDX_W-1:0] win_end,
   input  logic [IDX_W-1:0] offset,
   input  logic             win_on,
   output logic [IDX_W-1:0] addr
);
   localparam int LEN_W = IDX_W + 1;

   generate
      if (CYCLE_EN) begin : g_cycle
         logic             in_win;
         logic [IDX_W-1:0] rel;
         logic [LEN_W-1:0] win_len;
         logic [LEN_W-1:0] sum;
         logic [LEN_W-1:0] wrapped;

         assign in_win  = win_on && (idx >= win_start) && (idx <= win_end);
         assign rel     = idx - win_start;
         assign win_len = {1'b0, win_end} - {1'b0, win_start} + LEN_W'(1);
         assign sum     = {1'b0, rel} + {1'b0, offset};
         assign wrapped = (sum >= win_len) ? (sum - win_len) : sum;
         assign addr    = in_win ? (win_start + IDX_W'(wrapped)) : idx;
      end else begin : g_plain
         assign addr = idx;
      end
   endgenerate

endmodule

// File: rtl/pcyc_ram.sv
module pcyc_ram #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/palette_cycler.sv
module palette_cycler
   import pcyc_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int CH_W     = 4,
   parameter int SPEED_W  = 8,
   parameter bit CYCLE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pix_valid,
   input  logic [IDX_W-1:0]    pix_index,
   input  logic                frame_start,
   input  logic                host_we,
   input  logic [1:0]          host_sel,
   input  logic [IDX_W-1:0]    host_addr,
   input  logic [3*CH_W-1:0]   host_data,
   output logic                rgb_valid,
   output logic [3*CH_W-1:0]   rgb_out
);
   localparam int RGB_W = 3 * CH_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("palette_cycler: IDX_W must lie in 1..12");
      end
      if (CH_W < 1) begin : g_bad_ch
         $error("palette_cycler: CH_W must be at least 1");
      end
      if (SPEED_W < 1 || RGB_W < SPEED_W || RGB_W < IDX_W) begin : g_bad_spd
         $error("palette_cycler: register fields must fit in host_data");
      end
   endgenerate

   logic [IDX_W-1:0]   win_start;
   logic [IDX_W-1:0]   win_end;
   logic [SPEED_W-1:0] speed;
   logic [IDX_W-1:0]   offset;
   logic               win_on;
   logic [IDX_W-1:0]   lut_addr;
   logic [RGB_W-1:0]   lut_data;
   logic               v1_q;
   logic               entry_we;

   assign entry_we = host_we && (host_sel == SEL_ENTRY);

   pcyc_ctrl #(
      .IDX_W   (IDX_W),
      .SPEED_W (SPEED_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_start  (frame_start),
      .host_we      (host_we),
      .host_sel     (host_sel),
      .host_idx_val (host_data[IDX_W-1:0]),
      .host_spd_val (host_data[SPEED_W-1:0]),
      .win_start    (win_start),
      .win_end      (win_end),
      .speed        (speed),
      .offset       (offset),
      .win_on       (win_on)
   );

   pcyc_remap #(
      .IDX_W    (IDX_W),
      .CYCLE_EN (CYCLE_EN)
   ) u_remap (
      .idx       (pix_index),
      .win_start (win_start),
      .win_end   (win_end),
      .offset    (offset),
      .win_on    (win_on),
      .addr      (lut_addr)
   );

   pcyc_ram #(
      .IDX_W  (IDX_W),
      .DATA_W (RGB_W)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (entry_we),
      .waddr (host_addr),
      .wdata (host_data),
      .re    (pix_valid),
      .raddr (lut_addr),
      .rdata (lut_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q      <= 1'b0;
         rgb_valid <= 1'b0;
         rgb_out   <= '0;
      end else begin
         v1_q      <= pix_valid;
         rgb_valid <= v1_q;
         if (v1_q) begin
            rgb_out <= lut_data;
         end
      end
   end

endmodule

// File: rtl/pcyc_checker.sv
module pcyc_checker #(
   parameter int IDX_W   = 8,
   parameter int SPEED_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_valid,
   input logic [IDX_W-1:0]   pix_index,
   input logic               host_we,
   input logic [1:0]         host_sel,
   input logic               rgb_valid,
   input logic [IDX_W-1:0]   lut_addr,
   input logic [IDX_W-1:0]   win_start,
   input logic [IDX_W-1:0]   win_end,
   input logic [SPEED_W-1:0] speed,
   input logic [IDX_W-1:0]   offset
);
   logic [1:0] since_rst;
   logic       cfg_wr;
   logic       in_win;

   assign cfg_wr = host_we && (host_sel != 2'd0);
   assign in_win = (win_start <= win_end) && (pix_index >= win_start)
                   && (pix_index <= win_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
      end else if (since_rst != 2'd2) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2) |-> (rgb_valid == $past(pix_valid, 2)));

   a_r7_outside_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !in_win) |-> (lut_addr == pix_index));

   a_r6_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && in_win) |-> ((lut_addr >= win_start) && (lut_addr <= win_end)));

   a_r6_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start <= win_end) |-> (offset <= (win_end - win_start)));

   a_r9_cfg_clears_offset: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (offset == '0));

   a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      ((speed == '0) && !cfg_wr) |=> $stable(offset));

   a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> ((offset == $past(offset)) || (offset == $past(offset) + IDX_W'(1))
                   || (offset == '0)));

endmodule

bind palette_cycler pcyc_checker #(
   .IDX_W   (IDX_W),
   .SPEED_W (SPEED_W)
) u_pcyc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_valid (pix_valid),
   .pix_index (pix_index),
   .host_we   (host_we),
   .host_sel  (host_sel),
   .rgb_valid (rgb_valid),
   .lut_addr  (lut_addr),
   .win_start (win_start),
   .win_end   (win_end),
   .speed     (speed),
   .offset    (offset)
);

// File: tb/test_palette_cycler.sv
module test_palette_cycler;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pix_valid;
   logic [7:0]  pix_index;
   logic        frame_start;
   logic        host_we;
   logic [1:0]  host_sel;
   logic [7:0]  host_addr;
   logic [11:0] host_data;
   logic        rgb_valid;
   logic [11:0] rgb_out;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req  = "R1";
   bit    finished = 1'b0;

   // behavioural reference state
   int m_mem [256];
   int m_start, m_end, m_speed, m_off, m_fcnt;
   int m_v1, m_rd;
   int e_valid, e_rgb;

   always #10 clk = ~clk;

   palette_cycler i_palette_cycler (
      .clk         (clk),
      .rst_n       (rst_n),
      .pix_valid   (pix_valid),
      .pix_index   (pix_index),
      .frame_start (frame_start),
      .host_we     (host_we),
      .host_sel    (host_sel),
      .host_addr   (host_addr),
      .host_data   (host_data),
      .rgb_valid   (rgb_valid),
      .rgb_out     (rgb_out)
   );

   function automatic int ref_map(int i);
      int len;
      if (m_start <= m_end && i >= m_start && i <= m_end) begin
         len = m_end - m_start + 1;
         return m_start + ((i - m_start + m_off) % len);
      end
      return i;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_start = 0; m_end = 0; m_speed = 0; m_off = 0; m_fcnt = 0;
         m_v1 = 0; m_rd = 0; e_valid = 0; e_rgb = 0;
      end else begin
         e_valid = m_v1;
         if (m_v1 != 0) e_rgb = m_rd;
         m_v1 = int'(pix_valid);
         if (pix_valid) m_rd = m_mem[ref_map(int'(pix_index))];
         if (host_we) begin
            case (host_sel)
               2'd0: m_mem[host_addr] = int'(host_data);
               2'd1: m_start = int'(host_data) & 255;
               2'd2: m_end   = int'(host_data) & 255;
               default: m_speed = int'(host_data) & 255;
            endcase
            if (host_sel != 2'd0) begin
               m_off = 0;
               m_fcnt = 0;
            end
         end else if (frame_start && m_start <= m_end && m_speed != 0) begin
            if (m_fcnt == m_speed - 1) begin
               m_fcnt = 0;
               m_off = (m_off + 1) % (m_end - m_start + 1);
            end else begin
               m_fcnt++;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !finished) begin
         check(rgb_valid === 1'(e_valid), cur_req, "rgb_valid",
               int'(rgb_valid), e_valid);
         if (e_valid != 0)
            check(rgb_out === 12'(e_rgb), cur_req, "rgb_out", int'(rgb_out), e_rgb);
      end
   end

   task automatic step(input logic pv, input logic [7:0] idx, input logic fs,
                       input logic we, input logic [1:0] sel,
                       input logic [7:0] ad, input logic [11:0] dt);
      pix_valid   = pv;
      pix_index   = idx;
      frame_start = fs;
      host_we     = we;
      host_sel    = sel;
      host_addr   = ad;
      host_data   = dt;
      @(negedge clk);
   endtask

   task automatic pix(input logic [7:0] idx);
      step(1'b1, idx, 1'b0, 1'b0, 2'd0, 8'd0, 12'd0);
   endtask

   task automatic hw(input logic [1:0] sel, input logic [7:0] ad, input logic [11:0] dt);
      step(1'b0, 8'd0, 1'b0, 1'b1, sel, ad, dt);
   endtask

   task automatic frame();
      step(1'b0, 8'd0, 1'b1, 1'b0, 2'd0, 8'd0, 12'd0);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0, 12'd0);
   endtask

   initial begin
      rst_n = 1'b0;
      pix_valid = 1'b0; pix_index = '0; frame_start = 1'b0;
      host_we = 1'b0; host_sel = '0; host_addr = '0; host_data = '0;
      repeat (3) @(negedge clk);
      // R1: outputs at reset
      check(rgb_valid === 1'b0, "R1", "rgb_valid in reset", int'(rgb_valid), 0);
      check(rgb_out === 12'h000, "R1", "rgb_out in reset", int'(rgb_out), 0);
      rst_n = 1'b1;

      cur_req = "R4";
      for (int i = 0; i < 256; i++) hw(2'd0, 8'(i), 12'((i * 149 + 7) & 12'hfff));

      cur_req = "R1";            // registers at zero: identity lookup
      for (int i = 0; i < 16; i++) pix(8'(i));
      idle(2);

      cur_req = "R2";
      for (int i = 0; i < 256; i++) pix(8'(255 - i));
      idle(2);

      cur_req = "R3";
      for (int i = 0; i < 40; i++)
         step(1'((i % 3) != 0), 8'(i * 7), 1'b0, 1'b0, 2'd0, 8'd0, 12'd0);
      idle(3);

      cur_req = "R5";            // same-cycle write returns old, then new
      step(1'b1, 8'd50, 1'b0, 1'b1, 2'd0, 8'd50, 12'hABC);
      pix(8'd50);
      step(1'b1, 8'd51, 1'b0, 1'b1, 2'd0, 8'd52, 12'h123);
      pix(8'd52);
      idle(3);

      cur_req = "R6";
      hw(2'd1, 8'd0, 12'hF0A);   // start 10, upper bits ignored (R4)
      hw(2'd2, 8'd0, 12'h00D);   // end 13
      hw(2'd3, 8'd0, 12'h001);   // speed 1
      for (int f = 0; f < 6; f++) begin
         frame();
         for (int i = 8; i < 16; i++) pix(8'(i));
      end
      idle(2);

      cur_req = "R8";
      hw(2'd3, 8'd0, 12'h003);
      for (int f = 0; f < 9; f++) begin
         frame();
         for (int i = 10; i < 14; i++) pix(8'(i));
      end
      hw(2'd3, 8'd0, 12'h000);
      for (int f = 0; f < 4; f++) begin
         frame();
         for (int i = 10; i < 14; i++) pix(8'(i));
      end
      idle(2);

      cur_req = "R7";
      hw(2'd1, 8'd0, 12'd20);
      hw(2'd2, 8'd0, 12'd5);
      hw(2'd3, 8'd0, 12'd1);
      for (int f = 0; f < 3; f++) begin
         frame();
         for (int i = 0; i < 32; i++) pix(8'(i));
      end
      idle(2);

      cur_req = "R9";
      hw(2'd1, 8'd0, 12'd0);
      hw(2'd2, 8'd0, 12'd255);
      for (int f = 0; f < 300; f++)
         step(1'b1, 8'(f * 3), 1'b1, 1'b0, 2'd0, 8'd0, 12'd0);
      // config write together with a frame pulse: write wins
      step(1'b1, 8'd9, 1'b1, 1'b1, 2'd3, 8'd0, 12'd2);
      for (int i = 0; i < 8; i++) pix(8'(i));
      frame();
      for (int i = 0; i < 8; i++) pix(8'(i));
      frame();
      for (int i = 0; i < 8; i++) pix(8'(i));
      idle(4);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule